// File: doc/BRIEF.md
# Link Bring-Up and Speed Upgrade Sequencer

This block brings a serial link up in a safe order. When started, it first sets the advertised maximum-speed field to generation 1 and only then enables link training. Success needs link-up high and in-training low in the same cycle, and the wait for it is bounded by a cycle count. If the target generation is 2, the block then raises the cap to 2 and issues a one-cycle directed speed-change request. It polls the speed-change busy status until it clears, then checks the link once more before it reports success. At success it latches the negotiated speed.

One variant never clears the busy status when no speed transition takes place. For that variant a configuration input skips the busy poll, and the sequencer goes straight to the second link check. Any timeout or exhausted poll budget starts a receiver recovery through a PHY register access port. The sequencer drops training enable and reads the receiver override register. It writes the register back with the data-enable and PLL-enable override bits set, holds for a set time, reads the register again and writes it back with those bits cleared. It then pulses done with the fail flag set and returns to idle.

States: IDLE, CAP (cap forced to 1), WAIT1 (first link wait), RAISE (cap to 2, request pulse), POLL (busy polling), RELINK (second link wait), REC_RD1, REC_WR1, REC_HOLD, REC_RD2, REC_WR2. Transitions:
- IDLE→CAP on start.
- CAP→WAIT1 always.
- WAIT1→IDLE on link success with a generation-1 target; WAIT1→RAISE on link success with a generation-2 target.
- RAISE→POLL normally; RAISE→RELINK when the skip flag is set.
- POLL→RELINK when busy reads 0.
- RELINK→IDLE on link success.
- WAIT1, POLL and RELINK go to REC_RD1 on timeout or when the poll budget is used up.
- The REC_* states advance in order on each completed PHY transfer, and REC_HOLD advances on timer expiry.
- REC_WR2→IDLE.

Top module: `link_bringup_ctrl`

## Requirements
- R1: After reset: max_speed_o=1, train_en_o=0, spd_chg_req_o=0, phy_req_o=0, done_o=0, fail_o=0, cur_speed_o=0.
- R2: A start in IDLE sets max_speed_o to 1 before train_en_o rises. On every rise of train_en_o, max_speed_o reads 1, even after an earlier generation-2 run.
- R3: Link success means link_up_i=1 and in_training_i=0 in the same cycle. Link-up with in-training high does not count. With no success within LINK_TIMEOUT cycles, the sequencer takes the failure path.
- R4: With target_gen2_i=0, link success gives a done pulse with fail_o=0 and cur_speed_o equal to link_speed_i. max_speed_o stays 1 and no speed-change request is made.
- R5: With target_gen2_i=1, after link success max_speed_o becomes 2 and exactly one single-cycle spd_chg_req_o pulse is issued, while max_speed_o already reads 2.
- R6: With skip_spd_wait_i=0, spd_busy_i is sampled every POLL_GAP cycles for up to POLL_MAX samples. A sample of 0 moves on to the second link check; POLL_MAX samples of 1 mean failure.
- R7: With skip_spd_wait_i=1, spd_busy_i is ignored and the sequencer goes straight to the second link check.
- R8: After a generation-2 upgrade, success is reported only after the R3 link criterion is met again within LINK_TIMEOUT cycles; otherwise the run fails.
- R9: On failure, train_en_o drops and PHY register 0x1005 is read, then written with bits 5 and 3 set (mask 0x0028) and all other bits kept. After at least REC_HOLD cycles it is read again and written with bits 5 and 3 cleared. Then done_o pulses with fail_o=1 and cur_speed_o=0.
- R10: phy_req_o stays high, with phy_we_o and phy_wdata_o stable, until phy_ack_i is sampled high. Only one transfer is outstanding at a time.
- R11: done_o lasts one cycle. fail_o and cur_speed_o hold until the next accepted start.
- R12: start_i is ignored outside IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted in IDLE only |
| target_gen2_i | input | 1 | 1 = upgrade to generation 2 after link-up |
| skip_spd_wait_i | input | 1 | Variant flag: skip the speed-change busy poll |
| link_up_i | input | 1 | Link-up status |
| in_training_i | input | 1 | Link-in-training status |
| spd_busy_i | input | 1 | Directed speed change still in progress |
| link_speed_i | input | 4 | Negotiated speed from the link status |
| max_speed_o | output | 4 | Advertised maximum-speed cap |
| train_en_o | output | 1 | Link training enable |
| spd_chg_req_o | output | 1 | One-cycle directed speed-change request |
| phy_req_o | output | 1 | PHY access request |
| phy_we_o | output | 1 | PHY access is a write |
| phy_addr_o | output | 16 | PHY register address |
| phy_wdata_o | output | 16 | PHY write data |
| phy_ack_i | input | 1 | PHY access acknowledge (one cycle) |
| phy_rdata_i | input | 16 | PHY read data, valid with acknowledge |
| done_o | output | 1 | Sequence finished pulse |
| fail_o | output | 1 | Last sequence failed |
| cur_speed_o | output | 4 | Speed latched at success, 0 otherwise |

## Verification
The assertions assume three things about the inputs:
- phy_ack_i is a single-cycle pulse that comes only while phy_req_o is high.
- link_speed_i is steady whenever the link is reported up.
- Every status input is synchronous to clk.

The bench PHY model raises acknowledge for exactly one cycle, one cycle after a request is seen, and never in any other cycle. The link stimulus changes link status, busy and speed only at falling edges and holds link_speed_i constant for each run.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_CAP,
        S_WAIT1,
        S_RAISE,
        S_POLL,
        S_RELINK,
        S_REC_RD1,
        S_REC_WR1,
        S_REC_HOLD,
        S_REC_RD2,
        S_REC_WR2
    } lbc_state_e;

    localparam logic [3:0]  LBC_GEN1     = 4'd1;
    localparam logic [3:0]  LBC_GEN2     = 4'd2;
    localparam logic [15:0] LBC_RX_FORCE = 16'h0028;
endpackage

// File: rtl/lbc_timer.sv
module lbc_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lbc_phy_port.sv
module lbc_phy_port #(
    parameter int          AW   = 16,
    parameter int          DW   = 16,
    parameter logic [AW-1:0] ADDR = 16'h1005
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          ack_i,
    input  logic [DW-1:0] rdata_i,
    output logic          req_o,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          done_o,
    output logic [DW-1:0] rdata_o
);
    logic          req_q, we_q, done_q;
    logic [DW-1:0] wd_q, rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            we_q   <= 1'b0;
            wd_q   <= '0;
            rd_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (req_q) begin
                if (ack_i) begin
                    req_q  <= 1'b0;
                    done_q <= 1'b1;
                    rd_q   <= rdata_i;
                end
            end else if (go_i) begin
                req_q <= 1'b1;
                we_q  <= we_i;
                wd_q  <= wdata_i;
            end
        end
    end

    assign req_o   = req_q;
    assign we_o    = we_q;
    assign addr_o  = ADDR;
    assign wdata_o = wd_q;
    assign done_o  = done_q;
    assign rdata_o = rd_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !ack_i |=> req_o && $stable(we_o) && $stable(wdata_o)); // R10
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !req_o); // R10
endmodule

// File: rtl/link_bringup_ctrl.sv
module link_bringup_ctrl
    import lbc_pkg::*;
#(
    parameter int            LINK_TIMEOUT = 20000,
    parameter int            POLL_MAX     = 200,
    parameter int            POLL_GAP     = 25000,
    parameter int            REC_HOLD     = 500000,
    parameter logic [15:0]   RX_OVRD_ADDR = 16'h1005
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        target_gen2_i,
    input  logic        skip_spd_wait_i,
    input  logic        link_up_i,
    input  logic        in_training_i,
    input  logic        spd_busy_i,
    input  logic [3:0]  link_speed_i,
    output logic [3:0]  max_speed_o,
    output logic        train_en_o,
    output logic        spd_chg_req_o,
    output logic        phy_req_o,
    output logic        phy_we_o,
    output logic [15:0] phy_addr_o,
    output logic [15:0] phy_wdata_o,
    input  logic        phy_ack_i,
    input  logic [15:0] phy_rdata_i,
    output logic        done_o,
    output logic        fail_o,
    output logic [3:0]  cur_speed_o
);
    localparam int TMAX1 = (LINK_TIMEOUT > POLL_GAP) ? LINK_TIMEOUT : POLL_GAP;
    localparam int TMAX  = (TMAX1 > REC_HOLD) ? TMAX1 : REC_HOLD;
    localparam int TW    = $clog2(TMAX + 1);
    localparam int PW    = $clog2(POLL_MAX + 1);

    lbc_state_e    state_q, state_d;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          go, go_we, op_done;
    logic [15:0]   go_wd, op_rdata, shadow_q, shadow_d;
    logic          fin_ok, fin_fail, poll_inc, poll_clr;
    logic [PW-1:0] poll_q;
    logic          gen2_q, skip_q, link_ok;
    logic [3:0]    max_q, cur_q;
    logic          train_q, req_q, done_q, fail_q;

    assign link_ok = link_up_i & ~in_training_i;

    lbc_timer #(.W(TW)) tmr_i (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
    );

    lbc_phy_port #(.AW(16), .DW(16), .ADDR(RX_OVRD_ADDR)) port_i (
        .clk(clk), .rst_n(rst_n), .go_i(go), .we_i(go_we), .wdata_i(go_wd),
        .ack_i(phy_ack_i), .rdata_i(phy_rdata_i), .req_o(phy_req_o), .we_o(phy_we_o),
        .addr_o(phy_addr_o), .wdata_o(phy_wdata_o), .done_o(op_done), .rdata_o(op_rdata)
    );

    // next state and strobes
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        go       = 1'b0;
        go_we    = 1'b0;
        shadow_d = shadow_q;
        go_wd    = shadow_q;
        fin_ok   = 1'b0;
        fin_fail = 1'b0;
        poll_inc = 1'b0;
        poll_clr = 1'b0;
        unique case (state_q)
            S_IDLE: if (start_i) state_d = S_CAP;
            S_CAP: begin
                state_d  = S_WAIT1;
                tmr_load = 1'b1;
                tmr_val  = TW'(LINK_TIMEOUT);
            end
            S_WAIT1: begin
                if (link_ok) begin
                    if (gen2_q) begin
                        state_d = S_RAISE;
                    end else begin
                        state_d = S_IDLE;
                        fin_ok  = 1'b1;
                    end
                end else if (tmr_zero) begin
                    state_d = S_REC_RD1;
                    go      = 1'b1;
                end
            end
            S_RAISE: begin
                tmr_load = 1'b1;
                if (skip_q) begin
                    state_d = S_RELINK;
                    tmr_val = TW'(LINK_TIMEOUT);
                end else begin
                    state_d  = S_POLL;
                    tmr_val  = TW'(POLL_GAP);
                    poll_clr = 1'b1;
                end
            end
            S_POLL: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (!spd_busy_i) begin
                        state_d = S_RELINK;
                        tmr_val = TW'(LINK_TIMEOUT);
                    end else if (poll_q == PW'(POLL_MAX - 1)) begin
                        state_d = S_REC_RD1;
                        go      = 1'b1;
                    end else begin
                        poll_inc = 1'b1;
                        tmr_val  = TW'(POLL_GAP);
                    end
                end
            end
            S_RELINK: begin
                if (link_ok) begin
                    state_d = S_IDLE;
                    fin_ok  = 1'b1;
                end else if (tmr_zero) begin
                    state_d = S_REC_RD1;
                    go      = 1'b1;
                end
            end
            S_REC_RD1: if (op_done) begin
                shadow_d = op_rdata | LBC_RX_FORCE;
                go_wd    = shadow_d;
                go       = 1'b1;
                go_we    = 1'b1;
                state_d  = S_REC_WR1;
            end
            S_REC_WR1: if (op_done) begin
                state_d  = S_REC_HOLD;
                tmr_load = 1'b1;
                tmr_val  = TW'(REC_HOLD);
            end
            S_REC_HOLD: if (tmr_zero) begin
                state_d = S_REC_RD2;
                go      = 1'b1;
            end
            S_REC_RD2: if (op_done) begin
                shadow_d = op_rdata & ~LBC_RX_FORCE;
                go_wd    = shadow_d;
                go       = 1'b1;
                go_we    = 1'b1;
                state_d  = S_REC_WR2;
            end
            S_REC_WR2: if (op_done) begin
                state_d  = S_IDLE;
                fin_fail = 1'b1;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_q    <= LBC_GEN1;
            train_q  <= 1'b0;
            req_q    <= 1'b0;
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
            cur_q    <= '0;
            gen2_q   <= 1'b0;
            skip_q   <= 1'b0;
            poll_q   <= '0;
            shadow_q <= '0;
        end else begin
            done_q   <= fin_ok | fin_fail;
            req_q    <= (state_q == S_WAIT1) && (state_d == S_RAISE);
            shadow_q <= shadow_d;
            if (state_q == S_IDLE && start_i) begin
                max_q  <= LBC_GEN1;
                fail_q <= 1'b0;
                cur_q  <= '0;
                gen2_q <= target_gen2_i;
                skip_q <= skip_spd_wait_i;
            end
            if (state_q == S_CAP) train_q <= 1'b1;
            if (state_q == S_WAIT1 && state_d == S_RAISE) max_q <= LBC_GEN2;
            if (state_d == S_REC_RD1 && state_q != S_REC_RD1) train_q <= 1'b0;
            if (fin_ok)   cur_q  <= link_speed_i;
            if (fin_fail) fail_q <= 1'b1;
            if (poll_clr)      poll_q <= '0;
            else if (poll_inc) poll_q <= poll_q + 1'b1;
        end
    end

    assign max_speed_o   = max_q;
    assign train_en_o    = train_q;
    assign spd_chg_req_o = req_q;
    assign done_o        = done_q;
    assign fail_o        = fail_q;
    assign cur_speed_o   = cur_q;

    AST_CAP_AT_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_en_o) |-> max_speed_o == LBC_GEN1); // R2
    AST_REQ_WITH_CAP2: assert property (@(posedge clk) disable iff (!rst_n)
        spd_chg_req_o |-> max_speed_o == LBC_GEN2); // R5
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        spd_chg_req_o |=> !spd_chg_req_o); // R5
    AST_NO_TRAIN_IN_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        phy_req_o |-> !train_en_o); // R9
    AST_FAIL_SPEED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && fail_o |-> cur_speed_o == 4'd0); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11
endmodule

// File: tb/link_bringup_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_bringup_ctrl_tb_top;
    localparam int LT = 40, PM = 4, PG = 3, RH = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, tgt = 1'b0, skp = 1'b0;
    logic link_up = 1'b0, in_tr = 1'b0, spd_busy = 1'b0;
    logic [3:0] link_speed = 4'd0;
    logic [3:0] max_speed, cur_speed;
    logic train_en, spd_req, phy_req, phy_we, done, fail;
    logic [15:0] phy_addr, phy_wdata;
    logic phy_ack = 1'b0;
    logic [15:0] phy_reg = 16'h0123;

    always #2 clk = ~clk;

    link_bringup_ctrl #(.LINK_TIMEOUT(LT), .POLL_MAX(PM), .POLL_GAP(PG), .REC_HOLD(RH)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .target_gen2_i(tgt),
        .skip_spd_wait_i(skp), .link_up_i(link_up), .in_training_i(in_tr),
        .spd_busy_i(spd_busy), .link_speed_i(link_speed), .max_speed_o(max_speed),
        .train_en_o(train_en), .spd_chg_req_o(spd_req), .phy_req_o(phy_req),
        .phy_we_o(phy_we), .phy_addr_o(phy_addr), .phy_wdata_o(phy_wdata),
        .phy_ack_i(phy_ack), .phy_rdata_i(phy_reg), .done_o(done), .fail_o(fail),
        .cur_speed_o(cur_speed)
    );

    typedef struct { bit fl; logic [3:0] spd; logic [3:0] mx; } exp_t;
    exp_t        sbq[$];
    logic [15:0] wq[$];
    int errs = 0, checks = 0, req_cnt = 0, done_cnt = 0, cyc = 0, last_wr = 0, wr_idx = 0;
    logic [15:0] shadow = 16'h0123;
    logic prev_train = 1'b0;

    function automatic void chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    // PHY model: single-cycle ack one cycle after request
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) phy_ack <= 1'b0;
        else begin
            if (phy_ack) chk(phy_req, "R10 req held until ack", {31'd0, phy_req}, 1);
            phy_ack <= phy_req && !phy_ack;
            if (phy_req && !phy_ack) begin
                chk(phy_addr == 16'h1005, "R9 phy address", {16'd0, phy_addr}, 32'h1005);
                if (phy_we) begin
                    phy_reg <= phy_wdata;
                    if (wq.size() == 0) chk(0, "R9 unexpected write", {16'd0, phy_wdata}, 0);
                    else begin
                        logic [15:0] e;
                        e = wq.pop_front();
                        chk(phy_wdata == e, "R9 write value", {16'd0, phy_wdata}, {16'd0, e});
                    end
                    if (wr_idx % 2 == 1)
                        chk(cyc - last_wr >= RH, "R9 hold time", cyc - last_wr, RH);
                    last_wr <= cyc;
                    wr_idx  <= wr_idx + 1;
                end
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (spd_req) req_cnt++;
            if (train_en && !prev_train)
                chk(max_speed == 4'd1, "R2 cap at training start", {28'd0, max_speed}, 1);
            prev_train = train_en;
            if (done) begin
                done_cnt++;
                if (sbq.size() == 0) chk(0, "R12 unexpected done", 1, 0);
                else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(fail == e.fl, "R11 fail flag", {31'd0, fail}, {31'd0, e.fl});
                    chk(cur_speed == e.spd, "R4 reported speed", {28'd0, cur_speed}, {28'd0, e.spd});
                    chk(max_speed == e.mx, "R5 speed cap at end", {28'd0, max_speed}, {28'd0, e.mx});
                end
            end
        end
    end

    // lmode: 0 no link, 1 clean link, 2 link with training stuck
    // bmode: 0 busy low, 1 busy clears after request, 2 busy stuck
    task automatic run_case(input bit g2, input bit sk, input int lmode, input int bmode,
                            input bit drop, input logic [3:0] spd, input bit efail,
                            input logic [3:0] emax, input int ereqs, input bit dbl);
        exp_t e;
        @(negedge clk);
        link_up = 1'b0; in_tr = 1'b0; spd_busy = (bmode != 0);
        link_speed = spd; tgt = g2; skp = sk;
        e.fl = efail; e.spd = efail ? 4'd0 : spd; e.mx = emax;
        sbq.push_back(e);
        if (efail) begin
            wq.push_back(shadow | 16'h0028);
            wq.push_back(shadow & ~16'h0028);
            shadow = shadow & ~16'h0028;
        end
        req_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!train_en) @(negedge clk);
        repeat (5) @(negedge clk);
        if (dbl) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        if (lmode == 1) link_up = 1'b1;
        else if (lmode == 2) begin link_up = 1'b1; in_tr = 1'b1; end
        if (bmode == 1) begin
            while (!spd_req) @(negedge clk);
            if (drop) link_up = 1'b0;
            repeat (5) @(negedge clk);
            spd_busy = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(req_cnt == ereqs, "R5 speed-change request count", req_cnt, ereqs);
        chk(wq.size() == 0, "R9 recovery writes complete", wq.size(), 0);
        @(negedge clk);
        link_up = 1'b0; in_tr = 1'b0; spd_busy = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(max_speed == 4'd1, "R1 reset cap", {28'd0, max_speed}, 1);
        chk(!train_en && !spd_req && !phy_req, "R1 reset controls", {29'd0, train_en, spd_req, phy_req}, 0);
        chk(!done && !fail && cur_speed == 0, "R1 reset status", {26'd0, done, fail, cur_speed}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R4 + R12: gen1 success, extra start while busy
        run_case(0, 0, 1, 0, 0, 4'd1, 0, 4'd1, 0, 1);
        repeat (120) @(negedge clk);
        chk(done_cnt == 1, "R12 start ignored while running", done_cnt, 1);
        chk(!fail && cur_speed == 4'd1, "R11 status held after done", {27'd0, fail, cur_speed}, 1);
        // R5 R6: gen2, busy clears
        run_case(1, 0, 1, 1, 0, 4'd2, 0, 4'd2, 1, 0);
        // R2: gen1 after gen2 returns cap to 1
        run_case(0, 0, 1, 0, 0, 4'd1, 0, 4'd1, 0, 0);
        // R7: skip variant, busy stuck yet success
        run_case(1, 1, 1, 2, 0, 4'd2, 0, 4'd2, 1, 0);
        // R6: busy stuck, poll budget exhausted
        run_case(1, 0, 1, 2, 0, 4'd2, 1, 4'd2, 1, 0);
        // R3: no link, timeout
        run_case(0, 0, 0, 0, 0, 4'd1, 1, 4'd1, 0, 0);
        // R3: link up but still training
        run_case(0, 0, 2, 0, 0, 4'd1, 1, 4'd1, 0, 0);
        // R8: link lost during upgrade
        run_case(1, 0, 1, 1, 1, 4'd2, 1, 4'd2, 1, 0);
        chk(phy_reg == 16'h0103, "R9 register restored", {16'd0, phy_reg}, 32'h0103);
        chk(sbq.size() == 0, "R11 all runs finished", sbq.size(), 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule